// File: doc/BRIEF.md
# Configuration Word Memory Command Controller

This block sits on the device side of a byte-wide configuration register window and gives the host access to a small nonvolatile store of 16-bit configuration words. The host fills two address bytes (a byte address, twice the word index) and, for stores, two data bytes. It then writes a small command code into the control byte and polls the completion bit of that same byte until it is set. Loads bring the addressed word back into the two data bytes. Stores take a programmable busy time and are accepted only while the store gate is open. The host opens the gate with an enable command and closes it with a disable command.

The storage is an internal array, and its contents persist across reset. The serial pins of a real memory part are not modelled. All host traffic uses plain strobes: a register write happens on any cycle where `host_wr` is high, and `host_rdata` is a combinational view of the register at `host_addr`. No streaming data path exists, so no valid/ready handshake or back-pressure applies.

Top module: `cfgmem_ctrl`

## Requirements
- R1: After reset, every register reads 0x00. This includes the control byte, so the completion bit is clear, and the store gate is closed.
- R2: The host writes and reads back the data-low byte at 0x38, data-high at 0x3A, address-low at 0x3C and address-high at 0x3E. Other offsets read 0x00, and writes to them have no effect.
- R3: The control byte at 0x36 reads as {4'b0, done, code[2:0]}. The code field is the last command code written (host_wdata[2:0]), and done is bit 3 (value 8). A write to 0x36 clears done in the cycle after the write.
- R4: Code 2 (load) copies word W into the data bytes one cycle after the control write, with the low byte at 0x38 and the high byte at 0x3A. Done is set in that same cycle.
- R5: The word index W is byte-address bits [8:1], where the byte address is {addr-high, addr-low}. Address bit 0 and address-high bits [7:1] are ignored.
- R6: Code 4 opens the store gate and code 7 closes it. Each completes one cycle after the control write.
- R7: Code 1 (store) with the gate open writes {data-high, data-low} into word W. Done stays clear for WR_BUSY cycles and is set WR_BUSY+1 cycles after the control write.
- R8: Code 1 with the gate closed leaves the memory unchanged and completes one cycle after the control write.
- R9: Code 0 (idle) and the unused codes 3, 5 and 6 complete one cycle after the control write. They change neither the memory nor the data bytes.
- R10: A control write during the busy time of a store abandons the remaining wait. The new command completes on its own timing, and the store already made stays in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Combinational readback of the register at host_addr |

## Verification
A register write lands on the rising edge where `host_wr` is sampled high. The cleared done bit is visible one cycle later. A load's data bytes, and the done bit of load, idle, unused, gate and refused-store commands, follow one cycle after that. A gated store keeps done clear through its WR_BUSY cycles, and done appears one cycle beyond them. The bench drives on falling edges and counts whole cycles from the control write before each readback. It checks done at the last clear cycle and again at the first set cycle. Memory contents are read back only through load commands and compared against a shadow array that the bench updates only for stores it expects to take effect.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h36;
  localparam logic [7:0] OFS_DLO  = 8'h38;
  localparam logic [7:0] OFS_DHI  = 8'h3A;
  localparam logic [7:0] OFS_ALO  = 8'h3C;
  localparam logic [7:0] OFS_AHI  = 8'h3E;

  localparam int CODE_W = 3;
  localparam int DW     = 16;

  typedef enum logic [CODE_W-1:0] {
    CMD_IDLE  = 3'd0,
    CMD_STORE = 3'd1,
    CMD_LOAD  = 3'd2,
    CMD_GATE1 = 3'd4,
    CMD_GATE0 = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    SQ_REST = 2'd0,
    SQ_EXEC = 2'd1,
    SQ_WAIT = 2'd2
  } seq_e;
endpackage

// File: rtl/cfgmem_regs.sv
module cfgmem_regs
  import cfgmem_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [7:0]        host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              ld_data,
  input  logic [DW-1:0]     ld_word,
  input  logic              done,
  input  logic [CODE_W-1:0] last_code,
  output logic [7:0]        host_rdata,
  output logic [DW-1:0]     data_word,
  output logic [IW-1:0]     word_idx,
  output logic              ctrl_wr,
  output logic [CODE_W-1:0] ctrl_code
);
  logic [7:0] dlo_q, dhi_q, alo_q, ahi_q;
  logic [15:0] byte_addr;
  logic unused_bits;

  assign ctrl_wr   = host_wr && (host_addr == OFS_CTRL);
  assign ctrl_code = host_wdata[CODE_W-1:0];
  assign byte_addr = {ahi_q, alo_q};
  assign word_idx  = byte_addr[IW:1];
  assign data_word = {dhi_q, dlo_q};
  assign unused_bits = ^{byte_addr[15:IW+1], byte_addr[0], host_wdata[7:CODE_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlo_q <= '0;
      dhi_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
    end else begin
      if (host_wr && host_addr == OFS_ALO) alo_q <= host_wdata;
      if (host_wr && host_addr == OFS_AHI) ahi_q <= host_wdata;
      if (ld_data) begin
        dlo_q <= ld_word[7:0];
        dhi_q <= ld_word[15:8];
      end else begin
        if (host_wr && host_addr == OFS_DLO) dlo_q <= host_wdata;
        if (host_wr && host_addr == OFS_DHI) dhi_q <= host_wdata;
      end
    end
  end

  always_comb begin
    case (host_addr)
      OFS_CTRL: host_rdata = {4'b0, done, last_code};
      OFS_DLO:  host_rdata = dlo_q;
      OFS_DHI:  host_rdata = dhi_q;
      OFS_ALO:  host_rdata = alo_q;
      OFS_AHI:  host_rdata = ahi_q;
      default:  host_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq
  import cfgmem_pkg::*;
#(
  parameter int WR_BUSY = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CODE_W-1:0] ctrl_code,
  output logic              done,
  output logic [CODE_W-1:0] last_code,
  output logic              gate_open,
  output logic              st_we,
  output logic              ld_data
);
  localparam int CW = (WR_BUSY < 2) ? 1 : $clog2(WR_BUSY);

  seq_e            state_q;
  logic [CW-1:0]   cnt_q;
  logic            exec_store;

  assign exec_store = (state_q == SQ_EXEC) && (last_code == CMD_STORE);
  assign st_we      = exec_store && gate_open;
  assign ld_data    = (state_q == SQ_EXEC) && (last_code == CMD_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_REST;
      cnt_q     <= '0;
      done      <= 1'b0;
      last_code <= CMD_IDLE;
      gate_open <= 1'b0;
    end else begin
      if (state_q == SQ_EXEC && last_code == CMD_GATE1) gate_open <= 1'b1;
      if (state_q == SQ_EXEC && last_code == CMD_GATE0) gate_open <= 1'b0;
      if (ctrl_wr) begin
        state_q   <= SQ_EXEC;
        last_code <= ctrl_code;
        done      <= 1'b0;
      end else begin
        case (state_q)
          SQ_EXEC: begin
            if (st_we) begin
              state_q <= SQ_WAIT;
              cnt_q   <= CW'(WR_BUSY - 1);
            end else begin
              state_q <= SQ_REST;
              done    <= 1'b1;
            end
          end
          SQ_WAIT: begin
            if (cnt_q == '0) begin
              state_q <= SQ_REST;
              done    <= 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: state_q <= SQ_REST;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
  parameter int WORDS = 256,
  parameter int W     = 16,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/cfgmem_ctrl.sv
module cfgmem_ctrl
  import cfgmem_pkg::*;
#(
  parameter int WORDS   = 256,
  parameter int WR_BUSY = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam int IW = $clog2(WORDS);

  logic              done_q, wen_q, st_we, ld_data, ctrl_wr;
  logic [CODE_W-1:0] last_code, ctrl_code;
  logic [DW-1:0]     data_word, mem_word;
  logic [IW-1:0]     word_idx;

  cfgmem_regs #(.IW(IW)) regs_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .ld_data(ld_data), .ld_word(mem_word),
    .done(done_q), .last_code(last_code), .host_rdata(host_rdata),
    .data_word(data_word), .word_idx(word_idx), .ctrl_wr(ctrl_wr),
    .ctrl_code(ctrl_code)
  );

  cfgmem_seq #(.WR_BUSY(WR_BUSY)) seq_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_code(ctrl_code),
    .done(done_q), .last_code(last_code), .gate_open(wen_q),
    .st_we(st_we), .ld_data(ld_data)
  );

  cfgmem_store #(.WORDS(WORDS), .W(DW)) store_i (
    .clk(clk), .we(st_we), .idx(word_idx), .wdata(data_word), .rdata(mem_word)
  );
endmodule

// File: rtl/cfgmem_ctrl_chk.sv
module cfgmem_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [7:0] host_addr,
  input logic [7:0] host_wdata,
  input logic       done,
  input logic       gate_open,
  input logic       mem_we
);
  logic cw;
  assign cw = host_wr && (host_addr == 8'h36);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!done && !gate_open));

  // R3
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> !done);

  // R4
  load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && host_wdata[2:0] == 3'd2) ##1 !cw |=> done);

  // R6
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && host_wdata[2:0] == 3'd4) ##1 !cw |=> gate_open);

  // R6
  gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && host_wdata[2:0] == 3'd7) ##1 !cw |=> !gate_open);

  // R7
  store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !cw) |=> !done);

  // R8
  refused_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && host_wdata[2:0] == 3'd1 && !gate_open && !$past(cw)) ##1 !cw |=> done);
endmodule

bind cfgmem_ctrl cfgmem_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .done(done_q), .gate_open(wen_q), .mem_we(st_we)
);

// File: tb/cfgmem_ctrl_tb_top.sv
module cfgmem_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [7:0] host_addr = 8'h00;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [15:0] model [256];

  logic [7:0] exp_q [$];
  string      tag_q [$];
  event       chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgmem_ctrl #(.WORDS(256), .WR_BUSY(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // monitor: pops the expected item and compares with the design output
  initial begin
    forever begin
      @(chk_ev);
      #1;
      begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        tests++;
        if (host_rdata !== e) begin
          fails++;
          $display("FAIL %s: addr=%02h actual=%02h expected=%02h", t, host_addr, host_rdata, e);
        end
      end
    end
  end

  task automatic expect_reg(input logic [7:0] a, input logic [7:0] e, input string t);
    host_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> chk_ev;
    #2;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic set_word(input logic [7:0] w);
    reg_write(8'h3C, {w[6:0], 1'b0});
    reg_write(8'h3E, {7'b0, w[7]});
  endtask

  task automatic issue(input logic [2:0] c);
    reg_write(8'h36, {5'b0, c});
    expect_reg(8'h36, {5'b0, c}, "R3 done cleared after control write");
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_store(input logic [7:0] w, input logic [15:0] v);
    set_word(w);
    reg_write(8'h38, v[7:0]);
    reg_write(8'h3A, v[15:8]);
    issue(3'd1);
    wait_cyc(BUSY);
    expect_reg(8'h36, 8'h01, "R7 done clear at end of busy time");
    wait_cyc(1);
    expect_reg(8'h36, 8'h09, "R7 done set after busy time");
    model[w] = v;
  endtask

  task automatic do_load(input logic [7:0] alo, input logic [7:0] ahi, input logic [7:0] w, input string t);
    reg_write(8'h3C, alo);
    reg_write(8'h3E, ahi);
    issue(3'd2);
    wait_cyc(1);
    expect_reg(8'h36, 8'h0A, t);
    expect_reg(8'h38, model[w][7:0], t);
    expect_reg(8'h3A, model[w][15:8], t);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        tests++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    expect_reg(8'h36, 8'h00, "R1 control after reset");
    expect_reg(8'h38, 8'h00, "R1 data-low after reset");
    expect_reg(8'h3A, 8'h00, "R1 data-high after reset");
    expect_reg(8'h3C, 8'h00, "R1 addr-low after reset");
    expect_reg(8'h3E, 8'h00, "R1 addr-high after reset");
    // R2
    reg_write(8'h3C, 8'h5A);
    expect_reg(8'h3C, 8'h5A, "R2 addr-low readback");
    reg_write(8'h3E, 8'hC1);
    expect_reg(8'h3E, 8'hC1, "R2 addr-high readback");
    reg_write(8'h38, 8'h3D);
    expect_reg(8'h38, 8'h3D, "R2 data-low readback");
    reg_write(8'h3A, 8'h96);
    expect_reg(8'h3A, 8'h96, "R2 data-high readback");
    reg_write(8'h40, 8'hFF);
    expect_reg(8'h40, 8'h00, "R2 unmapped offset reads zero");
    reg_write(8'h37, 8'hFF);
    expect_reg(8'h36, 8'h00, "R2 write to unmapped offset ignored");
    // R6 open gate
    issue(3'd4);
    wait_cyc(1);
    expect_reg(8'h36, 8'h0C, "R6 gate open completes");
    // R7 stores, including first and last words
    do_store(8'd5, 16'h1234);
    do_store(8'd255, 16'hA55A);
    do_store(8'd0, 16'h00C3);
    // R6 close gate
    issue(3'd7);
    wait_cyc(1);
    expect_reg(8'h36, 8'h0F, "R6 gate close completes");
    // R8 refused store
    set_word(8'd5);
    reg_write(8'h38, 8'hEF);
    reg_write(8'h3A, 8'hBE);
    issue(3'd1);
    wait_cyc(1);
    expect_reg(8'h36, 8'h09, "R8 refused store completes in one cycle");
    do_load(8'h0A, 8'h00, 8'd5, "R8 word unchanged after refused store");
    // R4 / R5
    do_load(8'h0B, 8'h00, 8'd5, "R5 address bit 0 ignored");
    do_load(8'hFE, 8'h01, 8'd255, "R4 load of last word");
    do_load(8'hFE, 8'h03, 8'd255, "R5 upper address bits ignored");
    do_load(8'h00, 8'h00, 8'd0, "R4 load of word 0");
    // R9
    issue(3'd0);
    wait_cyc(1);
    expect_reg(8'h36, 8'h08, "R9 idle completes");
    issue(3'd5);
    wait_cyc(1);
    expect_reg(8'h36, 8'h0D, "R9 unused code completes");
    expect_reg(8'h38, 8'hC3, "R9 data-low untouched");
    expect_reg(8'h3A, 8'h00, "R9 data-high untouched");
    // R10
    issue(3'd4);
    wait_cyc(1);
    set_word(8'd6);
    reg_write(8'h38, 8'h77);
    reg_write(8'h3A, 8'h77);
    issue(3'd1);
    model[6] = 16'h7777;
    wait_cyc(2);
    issue(3'd2);
    wait_cyc(1);
    expect_reg(8'h36, 8'h0A, "R10 new command ends wait");
    expect_reg(8'h38, 8'h77, "R10 store kept");
    expect_reg(8'h3A, 8'h77, "R10 store kept");
    wait_cyc(BUSY);
    expect_reg(8'h36, 8'h0A, "R10 no stale completion");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule